// File: doc/BRIEF.md
# CCD Clocking-Unit Waveform Sequencer

This block produces the readout timing of a CCD from a small set of stored clocking units. A clocking unit is a short list of steps that performs one action, such as moving the image area down a row or moving the serial register along one pixel. Each step is a 64-bit state word and a hold time in system clock cycles. The low 32 bits of the state word drive the CCD clock lines. The high 32 bits drive internal controls, and one of those bits starts an ADC conversion on the video channels.

A short sequence program runs the units in order. Each program instruction runs one unit a counted number of times. Two levels of counted loops let a serial-shift unit run inside a row loop, so a whole frame is read out row by row. The host loads steps, unit boundaries, program and idle word through a simple write port while the sequencer is stopped. It then pulses start. The run ends on an end instruction, or at the next unit boundary after an abort request. All 64 outputs come from one register, so every line changes on the same clock edge.

Top module: `ccd_wave_seq`

## Requirements
- R1: After reset, `clk_out`, `ctl_out`, `adc_conv`, `busy` and `done` are all low.
- R2: A step entry is written with `wr_sel`=0 (state word, `wr_data[31:0]` CCD clocks, `wr_data[63:32]` controls) and `wr_sel`=1 (hold, `wr_data[15:0]`), at step index `wr_addr`. While a step runs, `clk_out` shows the state word's low half and `ctl_out` shows its high half. Both halves update on the same edge and are held for the hold count in cycles. A hold of 0 lasts 1 cycle.
- R3: A unit is written with `wr_sel`=2 at unit index `wr_addr`, with its first step in `wr_data[7:0]` and its last step in `wr_data[15:8]`. Its steps run in order, first to last. A run instruction repeats the unit its count of times with no gap between passes. A count of 0 runs it once.
- R4: A program instruction is written with `wr_sel`=3 at `wr_addr`: count in `[15:0]`, unit in `[23:16]`, opcode in `[25:24]` (0 run unit, 1 open loop, 2 close loop, 3 end). A close jumps back to just after its matching open until the open's count is used up. Two loop levels nest. Each instruction fetch adds one cycle to the last step that precedes it.
- R5: When an end instruction is fetched, `done` rises and `busy` falls on the next edge. The outputs show the idle word (`wr_sel`=4) one edge after that.
- R6: Every host write is ignored while `busy` is high.
- R7: An abort pulse during a run ends it only after the current unit pass finishes its last step. The sequencer then stops as it does at an end instruction.
- R8: `adc_conv` is a one-cycle pulse, aligned with `ctl_out`, whenever control bit 0 goes from low to high. It stays a single pulse even when the bit is held high for several cycles.
- R9: A start pulse while idle raises `busy` and clears `done` on the next edge. The program then begins at instruction 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 3 | Write target: step state, step hold, unit, instruction, idle word |
| wr_addr | input | 8 | Entry index within the target |
| wr_data | input | 64 | Write data |
| start | input | 1 | Begin the program at instruction 0 |
| abort | input | 1 | Stop at the next unit boundary |
| clk_out | output | 32 | CCD clock lines |
| ctl_out | output | 32 | Internal control lines |
| adc_conv | output | 1 | One-cycle ADC conversion request |
| busy | output | 1 | Program running |
| done | output | 1 | Last run has finished |

## Verification
The assertions assume that the host leaves the memories alone during a run and that every unit's last step is not below its first step. They also assume that no close instruction appears without an open instead of relying on a defined result for it. The stimulus loads every table only while the sequencer is idle. It uses well-ordered units and balanced loop pairs. Writes during a run appear only in the one case that checks they are ignored, and abort is only ever a single-cycle pulse inside a run.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [1:0] {
    OP_RUN  = 2'd0,
    OP_OPEN = 2'd1,
    OP_CLOSE = 2'd2,
    OP_END  = 2'd3
  } seq_op_e;

  typedef struct packed {
    seq_op_e     op;
    logic [7:0]  unit;
    logic [15:0] count;
  } seq_instr_t;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_FETCH = 2'd1,
    ENG_STEP  = 2'd2
  } eng_state_e;

  localparam logic [2:0] WSEL_STATE = 3'd0;
  localparam logic [2:0] WSEL_HOLD  = 3'd1;
  localparam logic [2:0] WSEL_UNIT  = 3'd2;
  localparam logic [2:0] WSEL_INSTR = 3'd3;
  localparam logic [2:0] WSEL_IDLE  = 3'd4;

endpackage

// File: rtl/ccd_seq_mem.sv
module ccd_seq_mem
  import ccd_seq_pkg::*;
#(
  parameter int STEPS = 32,
  parameter int UNITS = 8,
  parameter int PROG  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lock,
  input  logic                     wr_en,
  input  logic [2:0]               wr_sel,
  input  logic [7:0]               wr_addr,
  input  logic [63:0]              wr_data,
  input  logic [$clog2(STEPS)-1:0] step_idx,
  output logic [63:0]              step_word,
  output logic [15:0]              step_hold,
  input  logic [$clog2(UNITS)-1:0] unit_idx,
  output logic [$clog2(STEPS)-1:0] unit_first,
  output logic [$clog2(STEPS)-1:0] unit_last,
  input  logic [$clog2(PROG)-1:0]  pc,
  output seq_instr_t               instr,
  output logic [63:0]              idle_word
);

  localparam int SW = $clog2(STEPS);
  localparam int UW = $clog2(UNITS);
  localparam int PW = $clog2(PROG);

  logic [63:0]   state_mem [STEPS];
  logic [15:0]   hold_mem  [STEPS];
  logic [SW-1:0] first_mem [UNITS];
  logic [SW-1:0] last_mem  [UNITS];
  seq_instr_t    prog_mem  [PROG];
  logic [63:0]   idle_q, idle_d;

  logic wr_ok, hit_step, hit_unit, hit_prog;

  always_comb begin
    wr_ok    = wr_en && !lock;
    hit_step = int'(wr_addr) < STEPS;
    hit_unit = int'(wr_addr) < UNITS;
    hit_prog = int'(wr_addr) < PROG;
  end

  always_ff @(posedge clk) begin
    if (wr_ok && hit_step && wr_sel == WSEL_STATE)
      state_mem[wr_addr[SW-1:0]] <= wr_data;
    if (wr_ok && hit_step && wr_sel == WSEL_HOLD)
      hold_mem[wr_addr[SW-1:0]] <= wr_data[15:0];
  end

  always_ff @(posedge clk) begin
    if (wr_ok && hit_unit && wr_sel == WSEL_UNIT) begin
      first_mem[wr_addr[UW-1:0]] <= wr_data[SW-1:0];
      last_mem[wr_addr[UW-1:0]]  <= wr_data[8 +: SW];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok && hit_prog && wr_sel == WSEL_INSTR)
      prog_mem[wr_addr[PW-1:0]] <= seq_instr_t'(wr_data[25:0]);
  end

  always_comb begin
    idle_d = idle_q;
    if (wr_ok && wr_sel == WSEL_IDLE) idle_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= '0;
    else        idle_q <= idle_d;
  end

  always_comb begin
    step_word  = state_mem[step_idx];
    step_hold  = hold_mem[step_idx];
    unit_first = first_mem[unit_idx];
    unit_last  = last_mem[unit_idx];
    instr      = prog_mem[pc];
    idle_word  = idle_q;
  end

  // R6: host writes are ignored during a run
  a_r6_idle_locked: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(idle_q));

endmodule

// File: rtl/ccd_seq_ctrl.sv
module ccd_seq_ctrl
  import ccd_seq_pkg::*;
#(
  parameter int STEPS  = 32,
  parameter int UNITS  = 8,
  parameter int PROG   = 16,
  parameter int LEVELS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     abort,
  input  seq_instr_t               instr,
  input  logic [$clog2(STEPS)-1:0] unit_first,
  input  logic [$clog2(STEPS)-1:0] unit_last,
  input  logic [15:0]              step_hold,
  output logic [$clog2(PROG)-1:0]  pc,
  output logic [$clog2(UNITS)-1:0] unit_sel,
  output logic [$clog2(STEPS)-1:0] step_ptr,
  output logic                     busy,
  output logic                     done,
  output logic                     load_step,
  output logic                     load_idle
);

  localparam int SW = $clog2(STEPS);
  localparam int UW = $clog2(UNITS);
  localparam int PW = $clog2(PROG);
  localparam int DW = $clog2(LEVELS + 1);

  eng_state_e    st_q, st_d;
  logic [PW-1:0] pc_q, pc_d;
  logic [DW-1:0] dep_q, dep_d;
  logic [PW-1:0] lpc_q [LEVELS];
  logic [PW-1:0] lpc_d [LEVELS];
  logic [15:0]   lcnt_q [LEVELS];
  logic [15:0]   lcnt_d [LEVELS];
  logic [UW-1:0] unit_q, unit_d;
  logic [SW-1:0] ptr_q, ptr_d;
  logic [15:0]   hold_q, hold_d;
  logic [15:0]   rep_q, rep_d;
  logic          abt_q, abt_d;
  logic          done_q, done_d;

  logic [15:0]   eff_hold, eff_cnt, top_cnt;
  logic [PW-1:0] top_pc, pc_inc;
  logic          unused_unit_bits;

  assign unused_unit_bits = ^instr.unit;

  always_comb begin
    eff_hold = (step_hold == 16'd0) ? 16'd1 : step_hold;
    eff_cnt  = (instr.count == 16'd0) ? 16'd1 : instr.count;
    pc_inc   = pc_q + 1'b1;
    top_cnt  = '0;
    top_pc   = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (l + 1 == int'(dep_q)) begin
        top_cnt = lcnt_q[l];
        top_pc  = lpc_q[l];
      end
    end
  end

  // next-state logic
  always_comb begin
    st_d   = st_q;
    pc_d   = pc_q;
    dep_d  = dep_q;
    unit_d = unit_q;
    ptr_d  = ptr_q;
    hold_d = hold_q;
    rep_d  = rep_q;
    done_d = done_q;
    abt_d  = abt_q || (abort && st_q != ENG_IDLE);
    for (int l = 0; l < LEVELS; l++) begin
      lpc_d[l]  = lpc_q[l];
      lcnt_d[l] = lcnt_q[l];
    end

    unique case (st_q)
      ENG_IDLE: begin
        abt_d = 1'b0;
        if (start) begin
          st_d   = ENG_FETCH;
          pc_d   = '0;
          dep_d  = '0;
          done_d = 1'b0;
        end
      end
      ENG_FETCH: begin
        if (abt_q || instr.op == OP_END) begin
          st_d   = ENG_IDLE;
          done_d = 1'b1;
        end else begin
          unique case (instr.op)
            OP_RUN: begin
              unit_d = instr.unit[UW-1:0];
              ptr_d  = unit_first;
              hold_d = '0;
              rep_d  = eff_cnt;
              st_d   = ENG_STEP;
            end
            OP_OPEN: begin
              for (int l = 0; l < LEVELS; l++) begin
                if (l == int'(dep_q)) begin
                  lpc_d[l]  = pc_inc;
                  lcnt_d[l] = eff_cnt;
                end
              end
              if (int'(dep_q) < LEVELS) dep_d = dep_q + 1'b1;
              pc_d = pc_inc;
            end
            OP_CLOSE: begin
              if (dep_q != '0 && top_cnt > 16'd1) begin
                for (int l = 0; l < LEVELS; l++) begin
                  if (l + 1 == int'(dep_q)) lcnt_d[l] = lcnt_q[l] - 16'd1;
                end
                pc_d = top_pc;
              end else begin
                if (dep_q != '0) dep_d = dep_q - 1'b1;
                pc_d = pc_inc;
              end
            end
            default: pc_d = pc_inc;
          endcase
        end
      end
      ENG_STEP: begin
        if (hold_q == eff_hold - 16'd1) begin
          hold_d = '0;
          if (ptr_q == unit_last) begin
            if (rep_q > 16'd1 && !abt_q) begin
              rep_d = rep_q - 16'd1;
              ptr_d = unit_first;
            end else begin
              pc_d = pc_inc;
              st_d = ENG_FETCH;
            end
          end else begin
            ptr_d = ptr_q + 1'b1;
          end
        end else begin
          hold_d = hold_q + 16'd1;
        end
      end
      default: st_d = ENG_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      pc_q   <= '0;
      dep_q  <= '0;
      unit_q <= '0;
      ptr_q  <= '0;
      hold_q <= '0;
      rep_q  <= '0;
      abt_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pc_q   <= pc_d;
      dep_q  <= dep_d;
      unit_q <= unit_d;
      ptr_q  <= ptr_d;
      hold_q <= hold_d;
      rep_q  <= rep_d;
      abt_q  <= abt_d;
      done_q <= done_d;
    end
  end

  for (genvar g = 0; g < LEVELS; g++) begin : g_loop_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lpc_q[g]  <= '0;
        lcnt_q[g] <= '0;
      end else begin
        lpc_q[g]  <= lpc_d[g];
        lcnt_q[g] <= lcnt_d[g];
      end
    end
  end

  always_comb begin
    pc        = pc_q;
    unit_sel  = (st_q == ENG_FETCH) ? instr.unit[UW-1:0] : unit_q;
    step_ptr  = ptr_q;
    busy      = st_q != ENG_IDLE;
    done      = done_q;
    load_step = st_q == ENG_STEP;
    load_idle = st_q == ENG_IDLE;
  end

  // R4: loop nesting never exceeds the supported depth
  a_r4_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(dep_q) <= LEVELS);

  // R2: the hold counter never passes the step's hold time
  a_r2_hold_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_STEP) |-> (hold_q < eff_hold));

  // R5: done is only shown while stopped
  a_r5_done_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: start from idle runs next cycle with done cleared
  a_r9_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));

  // R7: a pending abort stops at the next fetch
  a_r7_abort_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_FETCH && abt_q) |=> (!busy && done));

endmodule

// File: rtl/ccd_seq_out.sv
module ccd_seq_out #(
  parameter int ADC_BIT = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_step,
  input  logic        load_idle,
  input  logic [63:0] step_word,
  input  logic [63:0] idle_word,
  output logic [31:0] clk_out,
  output logic [31:0] ctl_out,
  output logic        adc_conv
);

  localparam int TRIG = 32 + ADC_BIT;

  logic [63:0] out_q, out_d;
  logic        adc_q, adc_d, out_en;

  always_comb begin
    out_en = load_step || load_idle;
    out_d  = load_step ? step_word : idle_word;
    adc_d  = out_en && out_d[TRIG] && !out_q[TRIG];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      adc_q <= 1'b0;
    end else begin
      if (out_en) out_q <= out_d;
      adc_q <= adc_d;
    end
  end

  assign clk_out  = out_q[31:0];
  assign ctl_out  = out_q[63:32];
  assign adc_conv = adc_q;

  // R8: conversion request lasts exactly one cycle
  a_r8_adc_single: assert property (@(posedge clk) disable iff (!rst_n)
    adc_conv |=> !adc_conv);

  // R8: the request coincides with the trigger bit being high
  a_r8_adc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    adc_conv |-> ctl_out[ADC_BIT]);

endmodule

// File: rtl/ccd_wave_seq.sv
module ccd_wave_seq
  import ccd_seq_pkg::*;
#(
  parameter int STEPS   = 32,
  parameter int UNITS   = 8,
  parameter int PROG    = 16,
  parameter int LEVELS  = 2,
  parameter int ADC_BIT = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [7:0]  wr_addr,
  input  logic [63:0] wr_data,
  input  logic        start,
  input  logic        abort,
  output logic [31:0] clk_out,
  output logic [31:0] ctl_out,
  output logic        adc_conv,
  output logic        busy,
  output logic        done
);

  localparam int SW = $clog2(STEPS);
  localparam int UW = $clog2(UNITS);
  localparam int PW = $clog2(PROG);

  seq_instr_t    instr;
  logic [SW-1:0] unit_first, unit_last, step_ptr;
  logic [UW-1:0] unit_sel;
  logic [PW-1:0] pc;
  logic [63:0]   step_word, idle_word;
  logic [15:0]   step_hold;
  logic          load_step, load_idle, busy_i;

  ccd_seq_mem #(.STEPS(STEPS), .UNITS(UNITS), .PROG(PROG)) u_mem (
    .clk(clk), .rst_n(rst_n), .lock(busy_i),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
    .step_idx(step_ptr), .step_word(step_word), .step_hold(step_hold),
    .unit_idx(unit_sel), .unit_first(unit_first), .unit_last(unit_last),
    .pc(pc), .instr(instr), .idle_word(idle_word)
  );

  ccd_seq_ctrl #(.STEPS(STEPS), .UNITS(UNITS), .PROG(PROG), .LEVELS(LEVELS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .instr(instr), .unit_first(unit_first), .unit_last(unit_last),
    .step_hold(step_hold), .pc(pc), .unit_sel(unit_sel), .step_ptr(step_ptr),
    .busy(busy_i), .done(done), .load_step(load_step), .load_idle(load_idle)
  );

  ccd_seq_out #(.ADC_BIT(ADC_BIT)) u_out (
    .clk(clk), .rst_n(rst_n), .load_step(load_step), .load_idle(load_idle),
    .step_word(step_word), .idle_word(idle_word),
    .clk_out(clk_out), .ctl_out(ctl_out), .adc_conv(adc_conv)
  );

  assign busy = busy_i;

endmodule

// File: tb/test_ccd_wave_seq.sv
module test_ccd_wave_seq;

  logic        clk, rst_n, wr_en, start, abort;
  logic [2:0]  wr_sel;
  logic [7:0]  wr_addr;
  logic [63:0] wr_data;
  logic [31:0] clk_out, ctl_out;
  logic        adc_conv, busy, done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [31:0] trc_clk [512];
  logic [31:0] trc_ctl [512];
  logic        trc_adc [512];
  int          trc_n;

  localparam int NRUN = 13;
  localparam logic [31:0] EXP_VAL [NRUN] = '{
    32'h5A, 32'h11, 32'h22, 32'h33, 32'h44, 32'h33, 32'h44,
    32'h11, 32'h22, 32'h33, 32'h44, 32'h33, 32'h44};
  localparam int EXP_LEN [NRUN] = '{3, 2, 2, 3, 1, 3, 3, 2, 2, 3, 1, 3, 2};

  ccd_wave_seq i_ccd_wave_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_addr(wr_addr), .wr_data(wr_data), .start(start), .abort(abort),
    .clk_out(clk_out), .ctl_out(ctl_out), .adc_conv(adc_conv),
    .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input int addr, input logic [63:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_addr = addr[7:0]; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // run from start, record each cycle until done; optional write or abort at a sample
  task automatic run_capture(input int wr_at, input int abort_at);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && done == 1'b0, "R9", "busy/done after start", {busy, done}, 2'b10);
    trc_n = 0;
    for (int k = 0; k < 500; k++) begin
      if (done) break;
      trc_clk[trc_n] = clk_out;
      trc_ctl[trc_n] = ctl_out;
      trc_adc[trc_n] = adc_conv;
      trc_n++;
      wr_en = 1'b0;
      abort = 1'b0;
      if (k == wr_at) begin
        wr_en = 1'b1; wr_sel = 3'd4; wr_addr = 8'd0; wr_data = 64'hFFFF_FFFF_FFFF_FFFF;
      end
      if (k == abort_at) abort = 1'b1;
      @(negedge clk);
    end
    wr_en = 1'b0;
    abort = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    wr_en = 0; wr_sel = 0; wr_addr = 0; wr_data = 0; start = 0; abort = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(clk_out == 0 && ctl_out == 0, "R1", "outputs after reset", {ctl_out, clk_out}, 0);
    chk(!busy && !done && !adc_conv, "R1", "status after reset", {busy, done, adc_conv}, 0);

    // load steps, units, idle word and loop program
    wr(3'd0, 0, {32'h1,   32'h11}); wr(3'd1, 0, 64'd2);
    wr(3'd0, 1, {32'h0,   32'h22}); wr(3'd1, 1, 64'd0);
    wr(3'd0, 2, {32'h100, 32'h33}); wr(3'd1, 2, 64'd3);
    wr(3'd0, 3, {32'h0,   32'h44}); wr(3'd1, 3, 64'd1);
    wr(3'd2, 0, 64'h0100);
    wr(3'd2, 1, 64'h0302);
    wr(3'd4, 0, {32'hA0, 32'h5A});
    wr(3'd3, 0, {38'd0, 2'd1, 8'd0, 16'd2});
    wr(3'd3, 1, {38'd0, 2'd0, 8'd0, 16'd1});
    wr(3'd3, 2, {38'd0, 2'd0, 8'd1, 16'd2});
    wr(3'd3, 3, {38'd0, 2'd2, 8'd0, 16'd0});
    wr(3'd3, 4, {38'd0, 2'd3, 8'd0, 16'd0});
    @(negedge clk);
    chk(clk_out == 32'h5A && ctl_out == 32'hA0, "R5", "idle word shown", {ctl_out, clk_out}, {32'hA0, 32'h5A});

    // main run with a write attempt in the middle (R6)
    run_capture(10, -1);
    chk(trc_n == 30, "R4", "cycles of looped program", trc_n, 30);
    begin
      int ri, len;
      ri = 0; len = 0;
      for (int i = 0; i < trc_n; i++) begin
        len++;
        if (i == trc_n - 1 || trc_clk[i+1] != trc_clk[i]) begin
          if (ri < NRUN) begin
            chk(trc_clk[i] == EXP_VAL[ri], "R4", $sformatf("segment %0d value", ri), trc_clk[i], EXP_VAL[ri]);
            chk(len == EXP_LEN[ri], "R2", $sformatf("segment %0d length", ri), len, EXP_LEN[ri]);
          end
          ri++;
          len = 0;
        end
      end
      chk(ri == NRUN, "R3", "segment count", ri, NRUN);
    end
    begin
      int pulses, bad;
      pulses = 0; bad = 0;
      for (int i = 0; i < trc_n; i++) begin
        if (trc_adc[i]) pulses++;
        if (i > 0 && trc_adc[i] && trc_adc[i-1]) bad++;
        if (trc_clk[i] == 32'h33 && trc_ctl[i] != 32'h100) bad++;
      end
      chk(pulses == 2, "R8", "adc pulse count", pulses, 2);
      chk(bad == 0, "R8", "adc single cycle and control alignment (R2)", bad, 0);
    end
    chk(done && !busy, "R5", "done at end", {done, busy}, 2'b10);
    chk(clk_out == 32'h44, "R5", "last step held while stopping", clk_out, 32'h44);
    @(negedge clk);
    chk(clk_out == 32'h5A && ctl_out == 32'hA0, "R6", "idle word not overwritten during run", {ctl_out, clk_out}, {32'hA0, 32'h5A});

    // abort program: unit1 many times, abort mid pass
    wr(3'd3, 0, {38'd0, 2'd0, 8'd1, 16'd100});
    wr(3'd3, 1, {38'd0, 2'd3, 8'd0, 16'd0});
    run_capture(-1, 5);
    chk(trc_n == 10, "R7", "cycles until abort stop", trc_n, 10);
    chk(trc_clk[trc_n-1] == 32'h44, "R7", "stopped after unit last step", trc_clk[trc_n-1], 32'h44);
    chk(done && !busy, "R7", "done after abort", {done, busy}, 2'b10);
    @(negedge clk);
    chk(clk_out == 32'h5A, "R7", "idle after abort", clk_out, 32'h5A);

    // repeat count of 0 runs once
    wr(3'd3, 0, {38'd0, 2'd0, 8'd0, 16'd0});
    run_capture(-1, -1);
    chk(trc_n == 5, "R3", "cycles with zero count", trc_n, 5);
    begin
      int n11;
      n11 = 0;
      for (int i = 0; i < trc_n; i++) if (trc_clk[i] == 32'h11) n11++;
      chk(n11 == 2, "R3", "single pass for zero count", n11, 2);
    end
    chk(trc_ctl[2] == 32'h1 && trc_clk[2] == 32'h11, "R2", "both halves on same edge", {trc_ctl[2], trc_clk[2]}, {32'h1, 32'h11});

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule